// File: doc/BRIEF.md
# Key-Search Unit with Block Counter

This block is one search unit that sits on a shared search bus. The host writes a block number to the unit. The unit then loads its key generator with the first key of that block and tests one candidate key per clock. Each key goes through a fixed-latency test pipeline. In this project the pipeline stands in for the cipher: it flags a key whose value equals the `target_key` input, `LATENCY` cycles after the key enters.

When a flag arrives, the generator freezes in that cycle and the unit stops. The key the host reads back is therefore the generator value at halt time, which is `LATENCY` above the key that matched. The host subtracts the latency itself. If the whole block is tested with no match, the unit drops both of its status flags.

The unit decodes one 8-bit bus address, set by a parameter, and ignores every other address. A read reply packs two status bits and the low 32 bits of the generator value. A unit that holds no block reports a key value of 1, so the host can probe for units that are present.

Top module: `keysrch_unit`

## Requirements
- R1: After reset, `bus_ack` is 0, `bus_rdata` is 0, and the unit is neither searching nor holding a block.
- R2: A request whose `bus_addr` differs from `UNIT_ID` gets no acknowledge. A write to such an address does not change the unit's state.
- R3: A request to `UNIT_ID` is acknowledged with `bus_ack` high for exactly the cycle after the request. A read reply has these fields: bit 0 is the key-valid flag, bit 1 is the running flag, bits 7:2 are zero, bits 39:8 hold the key field, and bits 47:40 are zero. Every non-read cycle gives `bus_rdata` of 0.
- R4: While the key-valid flag is clear, the key field of a read reply is 1.
- R5: A write loads the generator with `wdata << BLK_BITS`, truncated to 32 bits. After the write edge, a read reports key-valid 1, running 1 and that start key.
- R6: While running, the generator increases by exactly one per clock. A read at edge r, for a write at edge w, reports start + (r-1-w).
- R7: A key K in the block that equals `target_key` halts the unit. Running goes to 0, key-valid stays 1, and the reported key freezes at K + `LATENCY`. The first read that shows running at 0 is issued `LATENCY`+2 edges after the edge where K appeared.
- R8: If no key of the block matches, the unit keeps running for `LATENCY` cycles after the last key so that the pipeline can drain. It then clears running and key-valid. A match on the last key of the block is still caught.
- R9: Writing a block again, after a halt or while running, restarts the search from the block's first key.
- R10: Keys outside the loaded block never cause a halt. This includes the generator values seen while the pipeline drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request strobe, one cycle per transaction |
| bus_wr | input | 1 | 1 for a write (block number), 0 for a read |
| bus_addr | input | 8 | Target unit address |
| bus_wdata | input | 48 | Write data, taken as the block number |
| bus_ack | output | 1 | Acknowledge, high for one cycle after a request to this unit |
| bus_rdata | output | 48 | Read reply: status bits and key field |
| target_key | input | 32 | Key value that the test pipeline flags |

## Verification
The bench sweeps the match position over every key of a small block. It checks that the frozen key is the match plus the latency, and it reads on exactly the last edge that still reports running. An off-by-one in the freeze or in the pipeline depth would report a key one away from the expected value, or drop running one read early. A match on the last key of the block is part of the sweep. The bench also puts the target just past the block end. A unit that ended the block before its pipeline drained would miss the last-key match. A unit that kept feeding the pipeline while it drained would halt on the key past the block end. Further cases are the presence probe before any load and after the block runs out, which must return 1, writes to a foreign address, and restarts in the middle of a run.

// File: rtl/keysrch_pkg.sv
package keysrch_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 48;
    localparam int KEY_W     = 32;
    localparam int STAT_W    = 8;
    localparam int KVALID_IX = 0;
    localparam int RUN_IX    = 1;
    localparam int KEY_LSB   = STAT_W;
    localparam int PAD_W     = DATA_W - KEY_W - STAT_W;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/keysrch_test_pipe.sv
module keysrch_test_pipe
    import keysrch_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             feed,
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] target,
    output logic             hit
);

    logic [LATENCY-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = '0;
        pipe_d[0] = feed && (key == target);
        for (int i = 1; i < LATENCY; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
        if (flush) begin
            pipe_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign hit = pipe_q[LATENCY-1];

    // R9: a reload empties the pipeline of stale flags
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

// File: rtl/keysrch_keygen.sv
module keysrch_keygen
    import keysrch_pkg::*;
#(
    parameter int BLK_BITS = 16,
    parameter int LATENCY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] block_num,
    input  logic              hit,
    output logic [KEY_W-1:0]  key,
    output logic              running,
    output logic              key_valid,
    output logic              feed
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             running;
        logic             kvalid;
        logic             draining;
        logic [CNT_W-1:0] cnt;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       last_key;
    logic       drained;

    always_comb begin
        st_d     = st_q;
        last_key = &st_q.key[BLK_BITS-1:0];
        drained  = st_q.draining && (st_q.cnt == CNT_W'(LATENCY));
        feed     = st_q.running && !st_q.draining && !hit;

        if (load) begin
            st_d.key      = KEY_W'(block_num << BLK_BITS);
            st_d.running  = 1'b1;
            st_d.kvalid   = 1'b1;
            st_d.draining = 1'b0;
            st_d.cnt      = '0;
        end else if (st_q.running) begin
            if (hit) begin
                st_d.running  = 1'b0;
                st_d.draining = 1'b0;
            end else if (drained) begin
                st_d.running  = 1'b0;
                st_d.kvalid   = 1'b0;
                st_d.draining = 1'b0;
            end else begin
                st_d.key = st_q.key + 1'b1;
                if (st_q.draining) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end else if (last_key) begin
                    st_d.draining = 1'b1;
                    st_d.cnt      = CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key       = st_q.key;
    assign running   = st_q.running;
    assign key_valid = st_q.kvalid;

    assert_load_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running && key_valid && (key[BLK_BITS-1:0] == '0));

    assert_halt_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hit && !load) |=> !running && key_valid && (key == $past(key)));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$past(load) && !$past(hit) && !load)
        |-> (key == $past(key) + 1'b1));

    assert_run_needs_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> key_valid);

endmodule

// File: rtl/keysrch_bus_slave.sv
module keysrch_bus_slave
    import keysrch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] UNIT_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [KEY_W-1:0]  key,
    input  logic              running,
    input  logic              key_valid,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              load,
    output logic [DATA_W-1:0] block_num
);

    bus_state_t       bs_d, bs_q;
    logic             selected;
    logic [KEY_W-1:0] key_field;

    always_comb begin
        selected  = bus_req && (bus_addr == UNIT_ID);
        load      = selected && bus_wr;
        block_num = bus_wdata;
        key_field = key_valid ? key : KEY_W'(1);

        bs_d.ack   = selected;
        bs_d.rdata = '0;
        if (selected && !bus_wr) begin
            bs_d.rdata[KVALID_IX]               = key_valid;
            bs_d.rdata[RUN_IX]                  = running;
            bs_d.rdata[KEY_LSB +: KEY_W]        = key_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_ack   = bs_q.ack;
    assign bus_rdata = bs_q.rdata;

    assert_ack_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == UNIT_ID) |=> bus_ack);

    assert_ignore_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_addr == UNIT_ID) |=> !bus_ack);

    assert_reply_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[KEY_LSB-1:RUN_IX+1] == '0) && (bus_rdata[DATA_W-1:DATA_W-PAD_W] == '0));

    assert_idle_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && bus_addr == UNIT_ID && !key_valid)
        |=> (bus_rdata[KEY_LSB +: KEY_W] == KEY_W'(1)));

endmodule

// File: rtl/keysrch_unit.sv
module keysrch_unit
    import keysrch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] UNIT_ID  = 8'h01,
    parameter int                BLK_BITS = 16,
    parameter int                LATENCY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [KEY_W-1:0]  target_key
);

    logic              load;
    logic [DATA_W-1:0] block_num;
    logic [KEY_W-1:0]  gen_key;
    logic              running;
    logic              key_valid;
    logic              feed;
    logic              hit;

    keysrch_bus_slave #(.UNIT_ID(UNIT_ID)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .key       (gen_key),
        .running   (running),
        .key_valid (key_valid),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .load      (load),
        .block_num (block_num)
    );

    keysrch_keygen #(.BLK_BITS(BLK_BITS), .LATENCY(LATENCY)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .block_num (block_num),
        .hit       (hit),
        .key       (gen_key),
        .running   (running),
        .key_valid (key_valid),
        .feed      (feed)
    );

    keysrch_test_pipe #(.LATENCY(LATENCY)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (load),
        .feed   (feed),
        .key    (gen_key),
        .target (target_key),
        .hit    (hit)
    );

    // R10: a halt is only ever taken on a flag from a key that was fed while searching
    assert_hit_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running) && key_valid) |-> $past(hit));

endmodule

// File: tb/keysrch_unit_tb.sv
`timescale 1ns/1ps
module keysrch_unit_tb;

    localparam logic [7:0] ID  = 8'h2A;
    localparam int         BB  = 6;
    localparam int         LAT = 3;
    localparam int         BLK = 1 << BB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [47:0] bus_wdata = '0;
    logic        bus_ack;
    logic [47:0] bus_rdata;
    logic [31:0] target_key = 32'hFFFF_FFFF;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int w_edge;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keysrch_unit #(.UNIT_ID(ID), .BLK_BITS(BB), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .target_key(target_key)
    );

    function automatic logic [47:0] reply(input logic kv, input logic run, input logic [31:0] k);
        return {8'h00, (kv ? k : 32'd1), 6'b0, run, kv};
    endfunction

    task automatic check(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [7:0] a, input logic [47:0] d);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_block(input logic [47:0] b);
        bus_op(1'b1, ID, b);
        w_edge = cyc;
        check(bus_ack == 1'b1, "R3", {47'b0, bus_ack}, 48'd1);
    endtask

    task automatic rd_at(input int r, input string req, input logic [47:0] exp);
        while (cyc < r - 1) @(negedge clk);
        bus_op(1'b0, ID, '0);
        check(bus_ack === 1'b1 && bus_rdata === exp, req, bus_rdata, exp);
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_ack === 1'b0, "R1", {47'b0, bus_ack}, 48'd0);
        check(bus_rdata === 48'd0, "R1", bus_rdata, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 foreign read gets no ack
        bus_op(1'b0, ID + 8'd1, '0);
        check(bus_ack === 1'b0, "R2", {47'b0, bus_ack}, 48'd0);
        // R4 presence probe on an idle unit
        rd_at(cyc + 1, "R4", reply(1'b0, 1'b0, 32'd0));
        // R3 ack lasts exactly one cycle, data returns to zero
        @(negedge clk);
        check(bus_ack === 1'b0 && bus_rdata === 48'd0, "R3", bus_rdata, 48'd0);
        // R2 foreign write leaves the unit idle
        bus_op(1'b1, 8'h00, 48'd5);
        check(bus_ack === 1'b0, "R2", {47'b0, bus_ack}, 48'd0);
        rd_at(cyc + 2, "R2", reply(1'b0, 1'b0, 32'd0));

        // R5 R6 R7 R8: match position swept over every key of a block
        for (int m = 0; m < BLK; m++) begin
            logic [31:0] s;
            s = 32'((m * 7 + 3) << BB);
            target_key = s + 32'(m);
            wr_block(48'(m * 7 + 3));
            rd_at(w_edge + 1, "R5", reply(1'b1, 1'b1, s));
            rd_at(w_edge + m + LAT + 1, "R7", reply(1'b1, 1'b1, s + 32'(m + LAT)));
            rd_at(w_edge + m + LAT + 2, "R7", reply(1'b1, 1'b0, s + 32'(m + LAT)));
        end

        // R6 per-cycle stepping observed at spaced reads
        target_key = 32'hFFFF_FFFF;
        wr_block(48'd9);
        for (int j = 2; j < 40; j += 5)
            rd_at(w_edge + j, "R6", reply(1'b1, 1'b1, 32'(9 << BB) + 32'(j - 1)));

        // R9 restart while running
        wr_block(48'd9);
        rd_at(w_edge + 1, "R9", reply(1'b1, 1'b1, 32'(9 << BB)));

        // R8 R10: target just past the block end never halts; block runs out
        wr_block(48'd12);
        target_key = 32'(13 << BB);
        rd_at(w_edge + BLK + LAT, "R8", reply(1'b1, 1'b1, 32'(13 << BB) + 32'(LAT - 1)));
        rd_at(w_edge + BLK + LAT + 1, "R8", reply(1'b0, 1'b0, 32'd0));
        rd_at(w_edge + BLK + LAT + 6, "R4", reply(1'b0, 1'b0, 32'd0));

        // R10: key just below the block never matches
        target_key = 32'(20 << BB) - 32'd1;
        wr_block(48'd20);
        rd_at(w_edge + BLK + LAT + 1, "R10", reply(1'b0, 1'b0, 32'd0));

        // R9 restart after a halt repeats the same frozen key
        target_key = 32'(20 << BB) + 32'd10;
        for (int k = 0; k < 2; k++) begin
            wr_block(48'd20);
            rd_at(w_edge + 1, "R9", reply(1'b1, 1'b1, 32'(20 << BB)));
            rd_at(w_edge + 10 + LAT + 4, "R9", reply(1'b1, 1'b0, 32'(20 << BB) + 32'(10 + LAT)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule